// File: doc/BRIEF.md
# Latin Square Cell Processor

This block is one cell of a two-dimensional array that fills in a partly colored Latin square, where every color must appear exactly once in each row and once in each column. In a wavelength-routing reading of the square, a color is a wavelength, a row is an input port and a column is an output port. The cell knows nothing global. It sees only a shared row bus, a shared column bus and a refill path from the edge of the array.

The cell holds a small bin of candidate colors as integer codes. While undecided, it strikes out any color that another cell has committed on the bus it is currently listening to. When one candidate is left, the cell commits to it. When none are left, it asks the edge for a refill. An external strobe can force a guess, which saves the rest of the candidates so that a later restore can bring them back. A committed cell broadcasts its color on the row bus in one cycle and on the column bus in the next. A cell that has been preset at start-up only broadcasts.

The bus inputs carry the combined drive of the other cells on that row or column. They never include the cell's own output.

Top module: `lsq_cell`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the cell drives no bus valid, no fill request, no commit and no contradiction, and reports a candidate count of 0.
- R2: If preset_vld_i is high in the first cycle after reset, the cell commits preset_color_i. It then keeps that color and broadcasts it for good, and ignores buses, fills, guess and restore.
- R3: The phase starts at 0 after reset and toggles every cycle. In phase 0 the cell reads only the row bus and, when committed, drives only the row bus. In phase 1 it does the same with the column bus.
- R4: An uncommitted cell with an empty bin holds fill_req_o high. A fill response of count k>0 loads lanes 0..min(k,BIN_DEPTH)-1 of fill_colors_i, where lane i sits at bits i*COLOR_W upward, and the count shows on cand_cnt_o in the next cycle.
- R5: While searching, a valid color on the active bus removes every candidate equal to it. A color that is not in the bin leaves the count unchanged.
- R6: If removals empty the bin, the cell raises fill_req_o in the next cycle.
- R7: If exactly one candidate is left after removal, the cell commits it in the next cycle. color_o then shows it and the candidate count reads 0.
- R8: With two or more candidates left, a guess_i strobe commits the lowest-lane candidate and saves the others.
- R9: restore_i, in any state other than preset or the first cycle after reset, clears a contradiction, reloads the saved candidates, clears the save and returns to searching. An empty save leads to a fill request.
- R10: contra_o rises after a fill response with count 0, or when a committed cell sees its own color on the active bus. It stays high, with no bus drive, until restore.
- R11: Each bus output pairs a valid bit with a color field, and the color field is 0 whenever the valid bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preset_vld_i | input | 1 | Preset this cell (sampled in the first cycle after reset) |
| preset_color_i | input | COLOR_W | Preset color |
| row_vld_i | input | 1 | Another cell in the row broadcasts |
| row_color_i | input | COLOR_W | Color on the row bus |
| col_vld_i | input | 1 | Another cell in the column broadcasts |
| col_color_i | input | COLOR_W | Color on the column bus |
| fill_vld_i | input | 1 | Refill response from the edge |
| fill_cnt_i | input | $clog2(BIN_DEPTH+1) | Number of colors in the refill |
| fill_colors_i | input | BIN_DEPTH*COLOR_W | Refill colors, lane 0 in the low bits |
| guess_i | input | 1 | Force a guess |
| restore_i | input | 1 | Reload saved candidates and clear a contradiction |
| row_vld_o | output | 1 | Cell drives the row bus |
| row_color_o | output | COLOR_W | Row bus color |
| col_vld_o | output | 1 | Cell drives the column bus |
| col_color_o | output | COLOR_W | Column bus color |
| fill_req_o | output | 1 | Refill request |
| commit_o | output | 1 | Cell holds a committed color |
| color_o | output | COLOR_W | Committed color, 0 otherwise |
| contra_o | output | 1 | Contradiction flag |
| cand_cnt_o | output | $clog2(BIN_DEPTH+1) | Candidates left in the bin |

## Verification
The bench goes after several corner cases:
- A color offered on the bus of the inactive phase. A cell that listens to both buses at once would lose a candidate here.
- A color absent from the bin. Wrong match logic would decrement the count.
- Duplicate entries that must all vanish in one cycle. This is the only way removal can empty the bin without first implicating.
- A fill count above the bin depth. Without clamping, the load would wrap to a small count.
- Guess followed by restore, repeated. A design that saved the wrong mask, or kept the save after a restore, would reload stale candidates.
- A refill of zero colors, and a committed cell hearing its own color. Both must latch the flag until restore.
- A preset cell that is sent every kind of stimulus. If it reacted to any of it, it would drop its color or start requesting fills.

// File: rtl/lsq_cell_pkg.sv
package lsq_cell_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_FILL,
    ST_SEARCH,
    ST_COMMIT,
    ST_PRESET,
    ST_CONTRA
  } cell_state_e;
endpackage

// File: rtl/lsq_cell_bin.sv
module lsq_cell_bin #(
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    load_cnt_i,
  input  logic [DEPTH*CW-1:0] load_colors_i,
  input  logic                rm_en_i,
  input  logic [CW-1:0]       rm_color_i,
  input  logic                commit_i,
  input  logic                guess_i,
  input  logic                restore_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [CNT_W-1:0]    cnt_n_o,
  output logic [CW-1:0]       low_color_o
);

  logic [CW-1:0]    slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q, save_q, hit, vld_n, low_oh, load_mask;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign hit[g]       = rm_en_i && vld_q[g] && (slot_q[g] == rm_color_i);
    assign load_mask[g] = (g < int'(load_cnt_i));
  end

  assign vld_n = vld_q & ~hit;

  always_comb begin
    cnt_o   = '0;
    cnt_n_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt_o   = cnt_o + CNT_W'(vld_q[i]);
      cnt_n_o = cnt_n_o + CNT_W'(vld_n[i]);
    end
  end

  // lowest surviving lane wins
  always_comb begin
    low_color_o = '0;
    low_oh      = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_n[i]) begin
        low_color_o = slot_q[i];
        low_oh      = '0;
        low_oh[i]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      save_q <= '0;
    end else if (restore_i) begin
      vld_q  <= save_q;
      save_q <= '0;
    end else if (load_i) begin
      vld_q  <= load_mask;
      save_q <= '0;
    end else if (commit_i) begin
      vld_q <= '0;
      if (guess_i) save_q <= vld_n & ~low_oh;
    end else begin
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (load_i && !restore_i) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= load_colors_i[i*CW +: CW];
    end
  end

  // R5
  count_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !restore_i) |=> (cnt_o <= $past(cnt_o)));

endmodule

// File: rtl/lsq_cell_bus.sv
module lsq_cell_bus #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drive_i,
  input  logic [CW-1:0] color_i,
  input  logic          row_vld_i,
  input  logic [CW-1:0] row_color_i,
  input  logic          col_vld_i,
  input  logic [CW-1:0] col_color_i,
  output logic          row_vld_o,
  output logic [CW-1:0] row_color_o,
  output logic          col_vld_o,
  output logic [CW-1:0] col_color_o,
  output logic          rd_vld_o,
  output logic [CW-1:0] rd_color_o
);

  logic phase_q; // 0: row, 1: column

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign rd_vld_o    = phase_q ? col_vld_i   : row_vld_i;
  assign rd_color_o  = phase_q ? col_color_i : row_color_i;
  assign row_vld_o   = drive_i && !phase_q;
  assign col_vld_o   = drive_i && phase_q;
  assign row_color_o = row_vld_o ? color_i : '0;
  assign col_color_o = col_vld_o ? color_i : '0;

  // R3
  row_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_vld_o |=> !row_vld_o);

  // R3
  col_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_vld_o |=> !col_vld_o);

endmodule

// File: rtl/lsq_cell_ctrl.sv
module lsq_cell_ctrl
  import lsq_cell_pkg::*;
#(
  parameter int CW    = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preset_vld_i,
  input  logic [CW-1:0]    preset_color_i,
  input  logic             fill_vld_i,
  input  logic [CNT_W-1:0] fill_cnt_i,
  input  logic             guess_i,
  input  logic             restore_i,
  input  logic             rd_vld_i,
  input  logic [CW-1:0]    rd_color_i,
  input  logic [CNT_W-1:0] cnt_n_i,
  input  logic [CW-1:0]    low_color_i,
  output cell_state_e      state_o,
  output logic [CW-1:0]    own_color_o,
  output logic             load_o,
  output logic             rm_en_o,
  output logic             commit_o,
  output logic             take_o,
  output logic             restore_o
);

  cell_state_e   state_q, state_d;
  logic [CW-1:0] own_q, own_d;

  assign restore_o = restore_i && (state_q inside {ST_FILL, ST_SEARCH, ST_COMMIT, ST_CONTRA});
  assign rm_en_o   = (state_q == ST_SEARCH) && rd_vld_i;

  always_comb begin
    state_d  = state_q;
    own_d    = own_q;
    load_o   = 1'b0;
    commit_o = 1'b0;
    take_o   = 1'b0;
    if (restore_o) begin
      state_d = ST_SEARCH;
    end else begin
      unique case (state_q)
        ST_INIT: begin
          if (preset_vld_i) begin
            state_d = ST_PRESET;
            own_d   = preset_color_i;
          end else begin
            state_d = ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_vld_i) begin
            if (fill_cnt_i == '0) begin
              state_d = ST_CONTRA;
            end else begin
              load_o  = 1'b1;
              state_d = ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (cnt_n_i == '0) begin
            state_d = ST_FILL;
          end else if (cnt_n_i == CNT_W'(1)) begin
            commit_o = 1'b1;
            own_d    = low_color_i;
            state_d  = ST_COMMIT;
          end else if (guess_i) begin
            commit_o = 1'b1;
            take_o   = 1'b1;
            own_d    = low_color_i;
            state_d  = ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          if (rd_vld_i && rd_color_i == own_q) state_d = ST_CONTRA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      own_q   <= '0;
    end else begin
      state_q <= state_d;
      own_q   <= own_d;
    end
  end

  assign state_o     = state_q;
  assign own_color_o = own_q;

  // R10
  contra_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONTRA && !restore_i) |=> (state_q == ST_CONTRA));

  // R2
  preset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRESET) |=> (state_q == ST_PRESET && $stable(own_q)));

endmodule

// File: rtl/lsq_cell.sv
module lsq_cell
  import lsq_cell_pkg::*;
#(
  parameter int COLOR_W   = 3,
  parameter int BIN_DEPTH = 4,
  localparam int CNT_W    = $clog2(BIN_DEPTH + 1),
  localparam int FILL_W   = BIN_DEPTH * COLOR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               preset_vld_i,
  input  logic [COLOR_W-1:0] preset_color_i,
  input  logic               row_vld_i,
  input  logic [COLOR_W-1:0] row_color_i,
  input  logic               col_vld_i,
  input  logic [COLOR_W-1:0] col_color_i,
  input  logic               fill_vld_i,
  input  logic [CNT_W-1:0]   fill_cnt_i,
  input  logic [FILL_W-1:0]  fill_colors_i,
  input  logic               guess_i,
  input  logic               restore_i,
  output logic               row_vld_o,
  output logic [COLOR_W-1:0] row_color_o,
  output logic               col_vld_o,
  output logic [COLOR_W-1:0] col_color_o,
  output logic               fill_req_o,
  output logic               commit_o,
  output logic [COLOR_W-1:0] color_o,
  output logic               contra_o,
  output logic [CNT_W-1:0]   cand_cnt_o
);

  cell_state_e        state;
  logic [COLOR_W-1:0] own_color, rd_color, low_color;
  logic               rd_vld, load, rm_en, do_commit, take, restore;
  logic [CNT_W-1:0]   cnt_n;

  lsq_cell_bus #(.CW(COLOR_W)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drive_i     (commit_o),
    .color_i     (own_color),
    .row_vld_i   (row_vld_i),
    .row_color_i (row_color_i),
    .col_vld_i   (col_vld_i),
    .col_color_i (col_color_i),
    .row_vld_o   (row_vld_o),
    .row_color_o (row_color_o),
    .col_vld_o   (col_vld_o),
    .col_color_o (col_color_o),
    .rd_vld_o    (rd_vld),
    .rd_color_o  (rd_color)
  );

  lsq_cell_ctrl #(.CW(COLOR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .preset_vld_i   (preset_vld_i),
    .preset_color_i (preset_color_i),
    .fill_vld_i     (fill_vld_i),
    .fill_cnt_i     (fill_cnt_i),
    .guess_i        (guess_i),
    .restore_i      (restore_i),
    .rd_vld_i       (rd_vld),
    .rd_color_i     (rd_color),
    .cnt_n_i        (cnt_n),
    .low_color_i    (low_color),
    .state_o        (state),
    .own_color_o    (own_color),
    .load_o         (load),
    .rm_en_o        (rm_en),
    .commit_o       (do_commit),
    .take_o         (take),
    .restore_o      (restore)
  );

  lsq_cell_bin #(.DEPTH(BIN_DEPTH), .CW(COLOR_W), .CNT_W(CNT_W)) u_bin (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .load_cnt_i    (fill_cnt_i),
    .load_colors_i (fill_colors_i),
    .rm_en_i       (rm_en),
    .rm_color_i    (rd_color),
    .commit_i      (do_commit),
    .guess_i       (take),
    .restore_i     (restore),
    .cnt_o         (cand_cnt_o),
    .cnt_n_o       (cnt_n),
    .low_color_o   (low_color)
  );

  assign commit_o   = (state == ST_COMMIT) || (state == ST_PRESET);
  assign color_o    = commit_o ? own_color : '0;
  assign fill_req_o = (state == ST_FILL);
  assign contra_o   = (state == ST_CONTRA);

  // R7
  commit_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (cand_cnt_o == '0));

  // R4
  fill_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_vld_i && fill_cnt_i != '0 && !restore_i) |=>
      (cand_cnt_o != '0 && !fill_req_o));

  // R10
  contra_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contra_o |-> (!row_vld_o && !col_vld_o));

endmodule

// File: tb/lsq_cell_test.sv
`timescale 1ns/1ps
module lsq_cell_test;
  localparam int CW = 3, D = 4, CNT_W = $clog2(D + 1);
  localparam int S_INIT = 0, S_FILL = 1, S_SRCH = 2, S_COMM = 3, S_PRE = 4, S_CON = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic preset_v = 0, row_v = 0, col_v = 0, fill_v = 0, guess = 0, restore = 0;
  logic [CW-1:0] preset_c = '0, row_c = '0, col_c = '0;
  logic [CNT_W-1:0] fill_n = '0;
  logic [D*CW-1:0] fill_c = '0;
  logic row_vld_o, col_vld_o, fill_req_o, commit_o, contra_o;
  logic [CW-1:0] row_color_o, col_color_o, color_o;
  logic [CNT_W-1:0] cand_cnt_o;

  always #2.5 clk = ~clk;

  lsq_cell #(.COLOR_W(CW), .BIN_DEPTH(D)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .preset_vld_i(preset_v), .preset_color_i(preset_c),
    .row_vld_i(row_v), .row_color_i(row_c),
    .col_vld_i(col_v), .col_color_i(col_c),
    .fill_vld_i(fill_v), .fill_cnt_i(fill_n), .fill_colors_i(fill_c),
    .guess_i(guess), .restore_i(restore),
    .row_vld_o(row_vld_o), .row_color_o(row_color_o),
    .col_vld_o(col_vld_o), .col_color_o(col_color_o),
    .fill_req_o(fill_req_o), .commit_o(commit_o), .color_o(color_o),
    .contra_o(contra_o), .cand_cnt_o(cand_cnt_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_st, m_ph, m_own;
  int q[$], sv[$];

  task automatic chk(string tag, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = S_INIT; m_ph = 0; m_own = 0;
    q.delete(); sv.delete();
  endtask

  task automatic model_edge();
    int bv, bc, n;
    int nq[$];
    bv = m_ph ? int'(col_v) : int'(row_v);
    bc = m_ph ? int'(col_c) : int'(row_c);
    if (restore && m_st != S_PRE && m_st != S_INIT) begin
      q = sv; sv.delete(); m_st = S_SRCH;
    end else begin
      case (m_st)
        S_INIT: if (preset_v) begin m_st = S_PRE; m_own = int'(preset_c); end
                else m_st = S_FILL;
        S_FILL: if (fill_v) begin
          n = (int'(fill_n) > D) ? D : int'(fill_n);
          if (n == 0) m_st = S_CON;
          else begin
            q.delete();
            for (int i = 0; i < n; i++) q.push_back(int'(fill_c[i*CW +: CW]));
            sv.delete();
            m_st = S_SRCH;
          end
        end
        S_SRCH: begin
          if (bv != 0) begin
            foreach (q[i]) if (q[i] != bc) nq.push_back(q[i]);
            q = nq;
          end
          if (q.size() == 0) m_st = S_FILL;
          else if (q.size() == 1) begin m_own = q[0]; q.delete(); m_st = S_COMM; end
          else if (guess) begin m_own = q[0]; sv = q[1:$]; q.delete(); m_st = S_COMM; end
        end
        S_COMM: if (bv != 0 && bc == m_own) m_st = S_CON;
        default: ;
      endcase
    end
    m_ph ^= 1;
  endtask

  task automatic compare(string tag);
    int cm;
    cm = (m_st == S_COMM || m_st == S_PRE) ? 1 : 0;
    chk(tag, "row_vld_o", int'(row_vld_o), (cm && m_ph == 0) ? 1 : 0);
    chk(tag, "row_color_o", int'(row_color_o), (cm && m_ph == 0) ? m_own : 0);
    chk(tag, "col_vld_o", int'(col_vld_o), (cm && m_ph == 1) ? 1 : 0);
    chk(tag, "col_color_o", int'(col_color_o), (cm && m_ph == 1) ? m_own : 0);
    chk(tag, "fill_req_o", int'(fill_req_o), (m_st == S_FILL) ? 1 : 0);
    chk(tag, "commit_o", int'(commit_o), cm);
    chk(tag, "color_o", int'(color_o), cm ? m_own : 0);
    chk(tag, "contra_o", int'(contra_o), (m_st == S_CON) ? 1 : 0);
    chk(tag, "cand_cnt_o", int'(cand_cnt_o), q.size());
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    preset_v = 0; row_v = 0; col_v = 0; row_c = '0; col_c = '0;
    fill_v = 0; guess = 0; restore = 0;
  endtask

  task automatic put_act(int c);
    if (m_ph == 0) begin row_v = 1; row_c = CW'(c); end
    else begin col_v = 1; col_c = CW'(c); end
  endtask

  task automatic put_ina(int c);
    if (m_ph == 0) begin col_v = 1; col_c = CW'(c); end
    else begin row_v = 1; row_c = CW'(c); end
  endtask

  task automatic fill(int n, int c0, int c1, int c2, int c3);
    fill_v = 1; fill_n = CNT_W'(n);
    fill_c[0*CW +: CW] = CW'(c0);
    fill_c[1*CW +: CW] = CW'(c1);
    fill_c[2*CW +: CW] = CW'(c2);
    fill_c[3*CW +: CW] = CW'(c3);
  endtask

  task automatic do_reset(bit pv, int pc);
    @(negedge clk);
    rst_ni = 0;
    model_reset();
    repeat (2) begin
      @(negedge clk);
      compare("R1");
    end
    preset_v = pv; preset_c = CW'(pc);
    rst_ni = 1;
  endtask

  initial begin
    model_reset();
    do_reset(0, 0);
    step("R1");                       // INIT -> FILL
    step("R4");
    fill(3, 5, 2, 6, 0); step("R4");
    chk("R4", "cand_cnt_o", int'(cand_cnt_o), 3);
    put_act(7); step("R5");           // absent color
    put_ina(5); step("R3");           // wrong-phase bus ignored
    put_act(5); step("R5");
    put_act(2); step("R7");           // one left -> commit 6
    chk("R7", "color_o", int'(color_o), 6);
    repeat (3) step("R3");
    put_ina(6); step("R10");          // own color on inactive bus ignored
    put_act(6); step("R10");
    chk("R10", "contra_o", int'(contra_o), 1);
    repeat (2) step("R10");
    restore = 1; step("R9");
    step("R9");                       // empty save -> fill
    fill(7, 1, 3, 4, 0); step("R4"); // clamp to depth
    chk("R4", "cand_cnt_o", int'(cand_cnt_o), 4);
    guess = 1; step("R8");
    chk("R8", "color_o", int'(color_o), 1);
    step("R8");
    restore = 1; step("R9");
    chk("R9", "cand_cnt_o", int'(cand_cnt_o), 3);
    guess = 1; step("R8");
    restore = 1; step("R9");
    put_act(0); step("R7");
    chk("R7", "color_o", int'(color_o), 4);
    restore = 1; step("R9");
    step("R6");
    fill(2, 4, 4, 0, 0); step("R4");
    put_act(4); step("R6");           // duplicates removed, bin empty
    chk("R6", "fill_req_o", int'(fill_req_o), 1);
    fill(4, 2, 2, 5, 1); step("R4");
    put_act(2); step("R5");
    chk("R5", "cand_cnt_o", int'(cand_cnt_o), 2);
    put_act(5); step("R7");
    restore = 1; step("R9");
    step("R9");
    fill(0, 1, 2, 3, 4); step("R10");
    repeat (2) step("R10");
    restore = 1; step("R9");
    step("R9");
    // preset cell
    do_reset(1, 5);
    step("R2");
    chk("R2", "color_o", int'(color_o), 5);
    put_act(5); guess = 1; restore = 1; step("R2");
    fill(3, 1, 2, 3, 0); step("R2");
    repeat (3) step("R2");
    chk("R11", "col_color_o", int'(col_vld_o ? 3'd0 : col_color_o), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule